// File: doc/BRIEF.md
# Shared-Domain Performance Counter Unit

This unit counts events for several processor cores from a shared, non-core clock domain. It has eight general event counters and one cycle counter, all 48 bits wide. Each general counter has its own selection register. That register sets which event code and which sub-event bits the counter accepts. It also holds a local enable bit and a bit that allows the counter to raise an interrupt. Every general counter watches its own event lane. On each cycle the lane presents a valid bit, an 8-bit code and 8 sub-event bits.

One global control register holds three groups of bits: the run enables for every counter, the bits that route the interrupt to up to four cores, and a freeze bit. When a counter wraps, it sets a sticky status bit. Software clears that bit through a write-one-to-clear register. Each core's interrupt line stays high while it is routed and an interrupt-enabled status bit is pending. When freeze is set, an interrupt-enabled wrap stops every counter in the same cycle. The counters stay stopped until software writes the enables again.

Software reaches all registers over a simple bus: a write strobe, a 5-bit word address, 64-bit write data and combinational read data.

Top module: `pmu_shared_top`

## Requirements
- R1: After reset, every counter, selection register, status bit and the control register is zero, and all core interrupt lines are low.
- R2: A general counter i increments by one on each clock where all of the following hold: its lane is valid, the lane code equals selection bits 7:0, the lane sub-event bits AND selection bits 15:8 is non-zero, selection bit 22 (local enable) is set, and control bit i is set. In every other cycle it holds its value.
- R3: The cycle counter increments by one on every clock while control bit 32 is set, and holds its value otherwise.
- R4: A bus write to a counter loads the low 48 bits of the write data and takes priority over an increment in the same cycle. A counter reads back zero-extended to 64 bits.
- R5: A counter wrap from all ones to zero sets a sticky status bit: bit i for general counter i, bit 32 for the cycle counter. Writing a one to the same bit of the clear register clears it. Zero bits in a clear write have no effect.
- R6: Core interrupt c is high exactly while control bit 48+c is set and some status bit is set whose counter may interrupt. A general counter may interrupt when its selection bit 20 is set. The cycle counter may always interrupt.
- R7: When control bit 63 is set and an interrupt-capable counter wraps, that same clock edge clears control bits 0–7 and 32 and keeps all other control bits. A wrap of a counter that may not interrupt leaves the control register unchanged.
- R8: Hardware never sets a counter enable bit. After a freeze, counters stay stopped until software writes the enables, and then counting resumes.
- R9: Address map: control 0x00, status 0x01 (writes ignored), clear 0x02 (reads zero), cycle counter 0x03, general counter i at 0x08+i, selection i at 0x10+i. Bits a register does not define read as zero. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 8 | Per-lane event valid pulse |
| evt_code | input | 64 | Per-lane 8-bit event code, lane i in bits 8i+7:8i |
| evt_unit | input | 64 | Per-lane 8-bit sub-event bits, lane i in bits 8i+7:8i |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register word address |
| cfg_wdata | input | 64 | Register write data |
| cfg_rdata | output | 64 | Register read data for cfg_addr |
| core_irq | output | 4 | Level interrupt per core |

## Verification
The embedded assertions check five rules on every cycle: a load wins over an increment, an increment moves a counter by exactly one, a wrap always sets its status bit, status bits only fall on a clear write, and enable bits never rise without a control write. They also check that a freeze clears the enables at the triggering edge and that no interrupt is raised without a pending, interrupt-capable status bit. Only the bench scenarios can show the rest: the event-matching rules across codes and sub-event masks, exact counts over known windows, the routing of one pending overflow to chosen cores, freeze being ignored for a counter that may not interrupt, and counting resuming once software re-enables after a freeze.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int PMU_NUM_GP    = 8;
  localparam int PMU_CNT_W     = 48;
  localparam int PMU_NUM_CORES = 4;
  localparam int PMU_CODE_W    = 8;
  localparam int PMU_ADDR_W    = 5;
  localparam int PMU_REG_W     = 64;

  localparam int SEL_CODE_LSB  = 0;
  localparam int SEL_UMASK_LSB = 8;
  localparam int SEL_IEN_BIT   = 20;
  localparam int SEL_LEN_BIT   = 22;
  localparam logic [PMU_REG_W-1:0] SEL_MASK = 64'h0000_0000_0050_FFFF;

  localparam int FX_BIT    = 32;
  localparam int ROUTE_LSB = 48;
  localparam int FRZ_BIT   = 63;

  localparam logic [PMU_ADDR_W-1:0] ADDR_CTRL     = 5'h00;
  localparam logic [PMU_ADDR_W-1:0] ADDR_STS      = 5'h01;
  localparam logic [PMU_ADDR_W-1:0] ADDR_CLR      = 5'h02;
  localparam logic [PMU_ADDR_W-1:0] ADDR_FX       = 5'h03;
  localparam logic [PMU_ADDR_W-1:0] ADDR_GP_BASE  = 5'h08;
  localparam logic [PMU_ADDR_W-1:0] ADDR_SEL_BASE = 5'h10;
endpackage

// File: rtl/pmu_event_match.sv
module pmu_event_match #(
  parameter int CODE_W = 8
) (
  input  logic              evt_valid,
  input  logic [CODE_W-1:0] evt_code,
  input  logic [CODE_W-1:0] evt_unit,
  input  logic [CODE_W-1:0] sel_code,
  input  logic [CODE_W-1:0] sel_umask,
  output logic              hit
);
  always_comb begin
    hit = evt_valid && (evt_code == sel_code) && (|(evt_unit & sel_umask));
  end
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_en,
  input  logic [W-1:0] ld_val,
  input  logic         inc_en,
  output logic [W-1:0] cnt_q,
  output logic         wrap
);
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (ld_en) begin
      cnt_d = ld_val;
    end else if (inc_en) begin
      cnt_d = cnt_q + 1'b1;
    end
    wrap = inc_en && !ld_en && (&cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (ld_en || inc_en) begin
      cnt_q <= cnt_d;
    end
  end

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (cnt_q == $past(ld_val))); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !ld_en) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2
endmodule

// File: rtl/pmu_irq_route.sv
module pmu_irq_route #(
  parameter int SRC_W     = 64,
  parameter int NUM_CORES = 4
) (
  input  logic [SRC_W-1:0]     sts,
  input  logic [SRC_W-1:0]     ien,
  input  logic [NUM_CORES-1:0] route,
  output logic [NUM_CORES-1:0] irq
);
  logic pending;

  always_comb begin
    pending = |(sts & ien);
    irq     = route & {NUM_CORES{pending}};
  end
endmodule

// File: rtl/pmu_shared_top.sv
module pmu_shared_top
  import pmu_pkg::*;
#(
  parameter int NUM_GP    = PMU_NUM_GP,
  parameter int CNT_W     = PMU_CNT_W,
  parameter int NUM_CORES = PMU_NUM_CORES,
  parameter int CODE_W    = PMU_CODE_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_GP-1:0]        evt_valid,
  input  logic [NUM_GP*CODE_W-1:0] evt_code,
  input  logic [NUM_GP*CODE_W-1:0] evt_unit,
  input  logic                     cfg_wr_en,
  input  logic [PMU_ADDR_W-1:0]    cfg_addr,
  input  logic [PMU_REG_W-1:0]     cfg_wdata,
  output logic [PMU_REG_W-1:0]     cfg_rdata,
  output logic [NUM_CORES-1:0]     core_irq
);
  localparam logic [PMU_REG_W-1:0] GP_EN_MASK = (64'd1 << NUM_GP) - 64'd1;
  localparam logic [PMU_REG_W-1:0] EN_MASK    = GP_EN_MASK | (64'd1 << FX_BIT);
  localparam logic [PMU_REG_W-1:0] ROUTE_MASK = ((64'd1 << NUM_CORES) - 64'd1) << ROUTE_LSB;
  localparam logic [PMU_REG_W-1:0] CTRL_MASK  = EN_MASK | ROUTE_MASK | (64'd1 << FRZ_BIT);

  logic [PMU_REG_W-1:0] ctrl_q, ctrl_d;
  logic [PMU_REG_W-1:0] sel_q [NUM_GP];
  logic [PMU_REG_W-1:0] sel_d [NUM_GP];
  logic [NUM_GP-1:0]    sts_gp_q, sts_gp_d;
  logic                 sts_fx_q, sts_fx_d;

  logic [CNT_W-1:0]     gp_cnt [NUM_GP];
  logic [CNT_W-1:0]     fx_cnt;
  logic [NUM_GP-1:0]    gp_hit, gp_inc, gp_wrap, gp_ien, wr_gp, wr_sel;
  logic                 fx_wrap;
  logic                 wr_ctrl, wr_clr, wr_fx, irq_trig;
  logic [PMU_REG_W-1:0] sts_vec, ien_vec, wrap_vec, clr_vec;

  always_comb begin
    wr_ctrl = cfg_wr_en && (cfg_addr == ADDR_CTRL);
    wr_clr  = cfg_wr_en && (cfg_addr == ADDR_CLR);
    wr_fx   = cfg_wr_en && (cfg_addr == ADDR_FX);
    clr_vec = wr_clr ? cfg_wdata : '0;
  end

  for (genvar i = 0; i < NUM_GP; i++) begin : g_gp
    assign wr_gp[i]  = cfg_wr_en && (cfg_addr == PMU_ADDR_W'(ADDR_GP_BASE + i));
    assign wr_sel[i] = cfg_wr_en && (cfg_addr == PMU_ADDR_W'(ADDR_SEL_BASE + i));
    assign gp_ien[i] = sel_q[i][SEL_IEN_BIT];
    assign gp_inc[i] = gp_hit[i] && sel_q[i][SEL_LEN_BIT] && ctrl_q[i];

    pmu_event_match #(.CODE_W(CODE_W)) u_match (
      .evt_valid (evt_valid[i]),
      .evt_code  (evt_code[i*CODE_W +: CODE_W]),
      .evt_unit  (evt_unit[i*CODE_W +: CODE_W]),
      .sel_code  (sel_q[i][SEL_CODE_LSB +: CODE_W]),
      .sel_umask (sel_q[i][SEL_UMASK_LSB +: CODE_W]),
      .hit       (gp_hit[i])
    );

    pmu_counter #(.W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld_en  (wr_gp[i]),
      .ld_val (cfg_wdata[CNT_W-1:0]),
      .inc_en (gp_inc[i]),
      .cnt_q  (gp_cnt[i]),
      .wrap   (gp_wrap[i])
    );
  end

  pmu_counter #(.W(CNT_W)) u_fx_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_en  (wr_fx),
    .ld_val (cfg_wdata[CNT_W-1:0]),
    .inc_en (ctrl_q[FX_BIT]),
    .cnt_q  (fx_cnt),
    .wrap   (fx_wrap)
  );

  // Flat views indexed by status bit position
  always_comb begin
    sts_vec  = '0;
    ien_vec  = '0;
    wrap_vec = '0;
    sts_vec[NUM_GP-1:0]  = sts_gp_q;
    ien_vec[NUM_GP-1:0]  = gp_ien;
    wrap_vec[NUM_GP-1:0] = gp_wrap;
    sts_vec[FX_BIT]  = sts_fx_q;
    ien_vec[FX_BIT]  = 1'b1;
    wrap_vec[FX_BIT] = fx_wrap;
    irq_trig = |(wrap_vec & ien_vec);
  end

  pmu_irq_route #(.SRC_W(PMU_REG_W), .NUM_CORES(NUM_CORES)) u_route (
    .sts   (sts_vec),
    .ien   (ien_vec),
    .route (ctrl_q[ROUTE_LSB +: NUM_CORES]),
    .irq   (core_irq)
  );

  // Next-state logic
  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d = cfg_wdata & CTRL_MASK;
    end
    if (ctrl_q[FRZ_BIT] && irq_trig) begin
      ctrl_d = ctrl_d & ~EN_MASK;
    end
    sts_gp_d = (sts_gp_q & ~clr_vec[NUM_GP-1:0]) | gp_wrap;
    sts_fx_d = (sts_fx_q & ~clr_vec[FX_BIT]) | fx_wrap;
    for (int i = 0; i < NUM_GP; i++) begin
      sel_d[i] = wr_sel[i] ? (cfg_wdata & SEL_MASK) : sel_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      sts_gp_q <= '0;
      sts_fx_q <= 1'b0;
      for (int i = 0; i < NUM_GP; i++) begin
        sel_q[i] <= '0;
      end
    end else begin
      ctrl_q   <= ctrl_d;
      sts_gp_q <= sts_gp_d;
      sts_fx_q <= sts_fx_d;
      for (int i = 0; i < NUM_GP; i++) begin
        sel_q[i] <= sel_d[i];
      end
    end
  end

  // Read mux
  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == ADDR_CTRL) begin
      cfg_rdata = ctrl_q;
    end else if (cfg_addr == ADDR_STS) begin
      cfg_rdata = sts_vec;
    end else if (cfg_addr == ADDR_FX) begin
      cfg_rdata = PMU_REG_W'(fx_cnt);
    end
    for (int i = 0; i < NUM_GP; i++) begin
      if (cfg_addr == PMU_ADDR_W'(ADDR_GP_BASE + i)) begin
        cfg_rdata = PMU_REG_W'(gp_cnt[i]);
      end
      if (cfg_addr == PMU_ADDR_W'(ADDR_SEL_BASE + i)) begin
        cfg_rdata = sel_q[i];
      end
    end
  end

  AST_WRAP_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrap_vec) |=> ((sts_vec & $past(wrap_vec)) == $past(wrap_vec))); // R5
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_clr |=> ((~sts_vec & $past(sts_vec)) == '0)); // R5
  AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (|core_irq) |-> (|(sts_vec & ien_vec))); // R6
  AST_FREEZE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[FRZ_BIT] && irq_trig) |=> ((ctrl_q & EN_MASK) == '0)); // R7
  AST_NO_SELF_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> ((ctrl_q & EN_MASK & ~$past(ctrl_q)) == '0)); // R8
endmodule

// File: tb/pmu_shared_top_tb_top.sv
module pmu_shared_top_tb_top;
  logic        clk;
  logic        rst_n;
  logic [7:0]  evt_valid;
  logic [63:0] evt_code;
  logic [63:0] evt_unit;
  logic        cfg_wr_en;
  logic [4:0]  cfg_addr;
  logic [63:0] cfg_wdata;
  logic [63:0] cfg_rdata;
  logic [3:0]  core_irq;

  int n_chk;
  int n_bad;
  bit done;

  pmu_shared_top dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_valid (evt_valid),
    .evt_code  (evt_code),
    .evt_unit  (evt_unit),
    .cfg_wr_en (cfg_wr_en),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .core_irq  (core_irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  localparam logic [4:0] A_CTRL = 5'h00, A_STS = 5'h01, A_CLR = 5'h02, A_FX = 5'h03;
  localparam logic [4:0] A_GP0 = 5'h08, A_SEL0 = 5'h10;
  localparam logic [63:0] ONES48 = 64'h0000_FFFF_FFFF_FFFF;

  // {write, address, data-or-expected}
  localparam logic [69:0] VEC [12] = '{
    {1'b1, 5'h10, 64'hFFFF_FFFF_FFFF_FFFF},
    {1'b0, 5'h10, 64'h0000_0000_0050_FFFF},
    {1'b1, 5'h00, 64'hFFFF_FFFF_FFFF_FFFF},
    {1'b0, 5'h00, 64'h800F_0001_0000_00FF},
    {1'b1, 5'h00, 64'h0},
    {1'b1, 5'h01, 64'hFFFF_FFFF_FFFF_FFFF},
    {1'b0, 5'h01, 64'h0},
    {1'b0, 5'h02, 64'h0},
    {1'b1, 5'h0B, 64'hFFFF_1234_5678_9ABC},
    {1'b0, 5'h0B, 64'h0000_1234_5678_9ABC},
    {1'b0, 5'h1F, 64'h0},
    {1'b1, 5'h10, 64'h0}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [63:0] d);
    cfg_addr  = a;
    cfg_wdata = d;
    cfg_wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [63:0] exp, input string tag);
    cfg_addr = a;
    #1;
    check(tag, cfg_rdata, exp);
  endtask

  task automatic chk_irq(input logic [3:0] exp, input string tag);
    #1;
    check(tag, {60'd0, core_irq}, {60'd0, exp});
  endtask

  task automatic lane0(input logic v, input logic [7:0] c, input logic [7:0] u);
    evt_valid[0]  = v;
    evt_code[7:0] = c;
    evt_unit[7:0] = u;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; evt_valid = '0; evt_code = '0; evt_unit = '0;
    cfg_wr_en = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_CTRL, 64'h0, "R1 ctrl");
    rd(A_STS, 64'h0, "R1 status");
    rd(A_GP0, 64'h0, "R1 gp0");
    rd(A_FX, 64'h0, "R1 fixed");
    rd(A_SEL0 + 5'd7, 64'h0, "R1 sel7");
    chk_irq(4'h0, "R1 irq");

    // Table walk: register map and field masking (R9, R4)
    for (int k = 0; k < 12; k++) begin
      if (VEC[k][69]) bus_wr(VEC[k][68:64], VEC[k][63:0]);
      else rd(VEC[k][68:64], VEC[k][63:0], "R9 R4 table");
    end

    // R2 event matching
    bus_wr(A_GP0, 64'h0);
    bus_wr(A_SEL0, 64'h0040_0C2A);
    bus_wr(A_CTRL, 64'h1);
    lane0(1'b1, 8'h2A, 8'h04); cycles(5);
    rd(A_GP0, 64'd5, "R2 match count");
    lane0(1'b1, 8'h2B, 8'h04); cycles(3);
    rd(A_GP0, 64'd5, "R2 wrong code");
    lane0(1'b1, 8'h2A, 8'h30); cycles(3);
    rd(A_GP0, 64'd5, "R2 mask miss");
    lane0(1'b0, 8'h2A, 8'h04);
    bus_wr(A_SEL0, 64'h0000_0C2A);
    lane0(1'b1, 8'h2A, 8'h04); cycles(3);
    rd(A_GP0, 64'd5, "R2 local enable off");
    lane0(1'b0, 8'h2A, 8'h04);
    bus_wr(A_SEL0, 64'h0040_0C2A);
    bus_wr(A_CTRL, 64'h0);
    lane0(1'b1, 8'h2A, 8'h04); cycles(3);
    rd(A_GP0, 64'd5, "R2 global enable off");
    lane0(1'b0, 8'h2A, 8'h04);

    // R4 write beats increment
    bus_wr(A_CTRL, 64'h1);
    lane0(1'b1, 8'h2A, 8'h04);
    bus_wr(A_GP0, 64'h100);
    rd(A_GP0, 64'h100, "R4 load priority");
    cycles(1);
    rd(A_GP0, 64'h101, "R4 count after load");
    lane0(1'b0, 8'h2A, 8'h04);
    bus_wr(A_CTRL, 64'h0);

    // R3 fixed counter
    bus_wr(A_FX, 64'h0);
    bus_wr(A_CTRL, 64'h1_0000_0000);
    cycles(7);
    rd(A_FX, 64'd7, "R3 fixed count");
    bus_wr(A_CTRL, 64'h0);
    rd(A_FX, 64'd8, "R3 fixed stop edge");
    cycles(3);
    rd(A_FX, 64'd8, "R3 fixed holds");

    // R5 / R6 overflow, status, routing
    bus_wr(A_SEL0, 64'h0050_0C2A);
    bus_wr(A_GP0, 64'h0000_FFFF_FFFF_FFFE);
    bus_wr(A_CTRL, 64'h0001_0000_0000_0001);
    lane0(1'b1, 8'h2A, 8'h04); cycles(1);
    rd(A_GP0, ONES48, "R5 before wrap");
    rd(A_STS, 64'h0, "R5 no status yet");
    chk_irq(4'h0, "R6 irq before wrap");
    cycles(1);
    lane0(1'b0, 8'h2A, 8'h04);
    rd(A_GP0, 64'h0, "R5 wrapped");
    rd(A_STS, 64'h1, "R5 status set");
    chk_irq(4'h1, "R6 core0 routed");
    bus_wr(A_CTRL, 64'h000A_0000_0000_0000);
    chk_irq(4'hA, "R6 cores 1 and 3");
    bus_wr(A_SEL0, 64'h0040_0C2A);
    chk_irq(4'h0, "R6 interrupt enable off");
    rd(A_STS, 64'h1, "R5 status sticky");
    bus_wr(A_SEL0, 64'h0050_0C2A);
    chk_irq(4'hA, "R6 interrupt enable back");
    bus_wr(A_CLR, 64'h2);
    rd(A_STS, 64'h1, "R5 clear other bit");
    bus_wr(A_CLR, 64'h1);
    rd(A_STS, 64'h0, "R5 cleared");
    chk_irq(4'h0, "R6 irq after clear");

    // Fixed counter overflow (R5, R6)
    bus_wr(A_CTRL, 64'h0);
    bus_wr(A_FX, ONES48);
    bus_wr(A_CTRL, 64'h0004_0001_0000_0000);
    cycles(1);
    rd(A_STS, 64'h1_0000_0000, "R5 fixed status bit 32");
    chk_irq(4'h4, "R6 fixed routed core2");
    bus_wr(A_CTRL, 64'h0);
    bus_wr(A_CLR, 64'h1_0000_0000);
    rd(A_STS, 64'h0, "R5 fixed cleared");

    // R7 freeze
    bus_wr(A_FX, 64'h0);
    bus_wr(A_GP0, 64'h0000_FFFF_FFFF_FFFE);
    lane0(1'b1, 8'h2A, 8'h04);
    bus_wr(A_CTRL, 64'h8001_0001_0000_0001);
    cycles(6);
    rd(A_CTRL, 64'h8001_0000_0000_0000, "R7 enables cleared");
    rd(A_GP0, 64'h0, "R7 gp0 stopped");
    rd(A_FX, 64'd2, "R7 fixed stopped");
    rd(A_STS, 64'h1, "R7 status");
    chk_irq(4'h1, "R7 irq");

    // R8 stays frozen, resumes on software write
    cycles(10);
    rd(A_GP0, 64'h0, "R8 gp0 still stopped");
    rd(A_FX, 64'd2, "R8 fixed still stopped");
    rd(A_CTRL, 64'h8001_0000_0000_0000, "R8 no self enable");
    bus_wr(A_CLR, 64'h1);
    bus_wr(A_CTRL, 64'h1);
    cycles(3);
    rd(A_GP0, 64'd3, "R8 resumes");
    lane0(1'b0, 8'h2A, 8'h04);

    // R7 wrap without interrupt enable does not freeze
    bus_wr(A_CTRL, 64'h0);
    bus_wr(A_SEL0, 64'h0040_0C2A);
    bus_wr(A_GP0, ONES48);
    bus_wr(A_CTRL, 64'h8000_0000_0000_0001);
    lane0(1'b1, 8'h2A, 8'h04); cycles(2);
    lane0(1'b0, 8'h2A, 8'h04);
    rd(A_CTRL, 64'h8000_0000_0000_0001, "R7 no freeze without ien");
    rd(A_GP0, 64'd1, "R7 keeps counting");
    rd(A_STS, 64'h1, "R5 status without ien");
    chk_irq(4'h0, "R6 no irq without ien");

    done = 1'b1;
    finish_run();
  end
endmodule